// File: doc/BRIEF.md
# Trigger-Started External-Edge Counter

This block is an up-counter that software arms but hardware starts. A slave-mode controller watches an edge-detected timer input; when the configured trigger edge arrives, it sets the run bit and raises a trigger flag, and the counter keeps its current value. From then on the counter advances once per qualified edge of an asynchronous external clock pin rather than on the system clock.

The external pin passes through a conditioning path before it reaches the counter. That path has a polarity inverter, a two-flop resynchronizer, an optional digital glitch filter, a rising-edge detector and an optional edge prescaler. The counter wraps to zero after it reaches a programmable reload value. Software configures the block through a write-only register port. The count, run bit and trigger flag are brought out as plain outputs.

Register writes are sampled on the rising clock edge while `wr_en` is high. The new value is visible on the outputs from the following cycle.

Top module: `trig_ext_counter`

## Requirements
- R1: After a synchronous active-low reset, `count_o` is 0, `run_o` is 0 and `trig_flag_o` is 0. The reload register resets to all ones.
- R2: When the slave register (address 1) holds mode bits [2:0] = 3'b110 and source bits [8:4] = 5'b00101, a qualified trigger-pin edge sets `run_o` and `trig_flag_o` in the same cycle. This happens on the 3rd rising clock edge after the pin changes, and `count_o` keeps its value.
- R3: With any other mode value or source value in address 1, trigger-pin edges leave `run_o` and `trig_flag_o` unchanged.
- R4: Address 3 bit 0 (P) and bit 1 (NP) pick the trigger edge. P=0 selects rising edges; this includes P=0 with NP=1. P=1 with NP=0 selects falling edges. P=1 with NP=1 selects both edges.
- R5: Address 2 bit 7 is the external-clock enable. When it is 1 and `run_o` is 1, with filter 0 and prescaler 0, every active edge of `ext_clk_pin` adds one to `count_o` on the 3rd rising clock edge after the pin changes. When either the enable bit or `run_o` is 0, `count_o` does not move.
- R6: Address 2 bit 6 selects the external edge. 0 counts rising edges and 1 counts falling edges; the opposite edge is never counted.
- R7: Address 2 bits [5:4] set the prescaler. Codes 0, 1, 2 and 3 pass every 1st, 2nd, 4th and 8th active edge. Any write to address 2 restarts the prescaler phase, so the first counted edge after the write is the Nth.
- R8: Address 2 bits [3:0] set the filter length N. If N is non-zero, a level change on the resynchronized pin is accepted only after it has held for N consecutive clocks. Shorter pulses are ignored, and each filter clock adds to the latency.
- R9: When the counter advances while it equals the reload value (address 5), it goes to 0 and `run_o` stays 1.
- R10: Writing address 4 with bit 0 = 0 clears `trig_flag_o`. Writing bit 0 = 1 has no effect. If a trigger occurs in the same cycle as the clearing write, the trigger wins.
- R11: Address 0 bit 0 writes `run_o` directly, so software can stop or restart the counter. A trigger edge that arrives while `run_o` is already 1 sets `trig_flag_o` but leaves `count_o` and `run_o` unchanged.
- R12: A write to address 6 loads `count_o`. This load takes precedence over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_pin | input | 1 | Asynchronous external clock pin |
| trig_pin | input | 1 | Asynchronous trigger input pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| count_o | output | 16 | Current counter value |
| run_o | output | 1 | Counter run bit |
| trig_flag_o | output | 1 | Trigger flag |

## Verification
Two situations are hard to reach from the ports. The first is getting a filtered, prescaled pin into a known state while changing its polarity, because flipping the polarity bit is itself an edge. The stimulus handles this in a fixed order. It writes the new polarity with the external-clock enable off and the filter at zero, then moves the pin to its new idle level, waits, and re-enables with the target filter and prescaler. That final write also fixes the prescaler phase. The second is the exact latency and the filter threshold. Directed pulses exactly one clock shorter than and equal to the filter length cover the threshold, and pin changes placed mid-cycle show the third-edge update. Random configurations and pulse trains then run against a wrap model.

// File: rtl/tec_pkg.sv
// Package: shared widths, register addresses and the external-path
// configuration record for the trigger-started external-edge counter.
package tec_pkg;

    localparam int FILT_W  = 4;                  // filter length field width
    localparam int PSC_W   = 2;                  // prescaler code width
    localparam int PDIV_W  = (1 << PSC_W) - 1;   // width of the edge divider
    localparam int ADDR_W  = 3;                  // register address width

    // Register addresses
    localparam logic [ADDR_W-1:0] A_RUN    = 3'd0;
    localparam logic [ADDR_W-1:0] A_SLAVE  = 3'd1;
    localparam logic [ADDR_W-1:0] A_EXTCFG = 3'd2;
    localparam logic [ADDR_W-1:0] A_TRGCFG = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAG   = 3'd4;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd5;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd6;

    // Slave-mode and trigger-source codes the block decodes
    localparam logic [2:0] MODE_TRIG_START = 3'b110;
    localparam logic [4:0] SRC_TRIG_PIN    = 5'b00101;

    // External-path configuration; bit order equals address 2 bits [7:0]
    typedef struct packed {
        logic              ext_en;
        logic              pol;
        logic [PSC_W-1:0]  presc;
        logic [FILT_W-1:0] filt;
    } ext_cfg_t;

endpackage

// File: rtl/tec_sync.sv
// Module: multi-stage resynchronizer for one asynchronous level.
// Assumes STAGES >= 2; output is the last stage, reset low.
module tec_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/tec_trig_edge.sv
// Module: trigger input edge detector. Resynchronizes the pin, then flags
// rising, falling or both edges according to the P/NP polarity bits.
// Assumes the pin is low during reset; P=0,NP=1 is treated as rising.
module tec_trig_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic pol_p,
    input  logic pol_np,
    output logic edge_o
);
    logic lvl_sync, lvl_d;
    logic rise, fall;

    tec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin), .q(lvl_sync)
    );

    // Hold the previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl_sync;
    end

    assign rise = lvl_sync & ~lvl_d;
    assign fall = ~lvl_sync & lvl_d;

    // Pick the qualifying edge set from the polarity bits
    always_comb begin
        unique case ({pol_p, pol_np})
            2'b10:   edge_o = fall;
            2'b11:   edge_o = rise | fall;
            default: edge_o = rise;
        endcase
    end
endmodule

// File: rtl/tec_ext_cond.sv
// Module: external clock conditioning. Polarity inversion, resynchronizer,
// optional stability filter, rising-edge detector and edge prescaler.
// Emits a one-cycle tick per qualified edge. Assumes a write to the
// configuration register pulses cfg_wr, which restarts the prescaler phase.
module tec_ext_cond
    import tec_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pin,
    input  ext_cfg_t cfg,
    input  logic     cfg_wr,
    output logic     tick
);
    logic              lvl_sync;
    logic              filt_lvl_q;
    logic [FILT_W-1:0] stab_q;
    logic              lvl, lvl_d;
    logic              edge_det;
    logic [PDIV_W-1:0] psc_q, psc_mask;
    logic              psc_full;

    tec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin ^ cfg.pol), .q(lvl_sync)
    );

    // Accept a new level only after it has held for cfg.filt clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_lvl_q <= 1'b0;
            stab_q     <= '0;
        end else if (cfg.filt == '0) begin
            filt_lvl_q <= lvl_sync;
            stab_q     <= '0;
        end else if (lvl_sync == filt_lvl_q) begin
            stab_q     <= '0;
        end else if (stab_q == cfg.filt - FILT_W'(1)) begin
            filt_lvl_q <= lvl_sync;
            stab_q     <= '0;
        end else begin
            stab_q     <= stab_q + FILT_W'(1);
        end
    end

    assign lvl = (cfg.filt == '0) ? lvl_sync : filt_lvl_q;

    // Hold the previous conditioned level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    assign edge_det = lvl & ~lvl_d;

    // Build the divider terminal mask from the prescaler code
    always_comb begin
        for (int i = 0; i < PDIV_W; i++) begin
            psc_mask[i] = (i < int'(cfg.presc));
        end
    end

    assign psc_full = (psc_q == psc_mask);

    // Count qualified edges; restart on a configuration write
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_wr)              psc_q <= '0;
        else if (edge_det && cfg.ext_en)   psc_q <= psc_full ? '0 : psc_q + PDIV_W'(1);
    end

    assign tick = edge_det && cfg.ext_en && psc_full;
endmodule

// File: rtl/trig_ext_counter.sv
// Module: trigger-started external-edge counter (top). Holds the register
// file, the slave-mode trigger decode and the counter with reload wrap.
// Assumes pins are low during reset and CNT_W >= 9 so slave fields fit.
module trig_ext_counter
    import tec_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk_pin,
    input  logic              trig_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count_o,
    output logic              run_o,
    output logic              trig_flag_o
);
    logic [CNT_W-1:0] cnt_q, reload_q;
    logic             run_q, flag_q;
    logic [2:0]       mode_q;
    logic [4:0]       src_q;
    ext_cfg_t         ext_q;
    logic             trg_p_q, trg_np_q;

    logic wr_run, wr_slave, wr_ext, wr_trg, wr_flag, wr_reload, wr_cnt;
    logic trig_edge, trig_hit, ext_tick, adv;

    // Address decode of the write port
    always_comb begin
        wr_run    = wr_en && (wr_addr == A_RUN);
        wr_slave  = wr_en && (wr_addr == A_SLAVE);
        wr_ext    = wr_en && (wr_addr == A_EXTCFG);
        wr_trg    = wr_en && (wr_addr == A_TRGCFG);
        wr_flag   = wr_en && (wr_addr == A_FLAG);
        wr_reload = wr_en && (wr_addr == A_RELOAD);
        wr_cnt    = wr_en && (wr_addr == A_COUNT);
    end

    // Configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            src_q    <= '0;
            ext_q    <= '0;
            trg_p_q  <= 1'b0;
            trg_np_q <= 1'b0;
            reload_q <= '1;
        end else begin
            if (wr_slave)  {src_q, mode_q} <= {wr_data[8:4], wr_data[2:0]};
            if (wr_ext)    ext_q           <= ext_cfg_t'(wr_data[7:0]);
            if (wr_trg)    {trg_np_q, trg_p_q} <= wr_data[1:0];
            if (wr_reload) reload_q        <= wr_data;
        end
    end

    tec_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk(clk), .rst_n(rst_n), .pin(trig_pin),
        .pol_p(trg_p_q), .pol_np(trg_np_q), .edge_o(trig_edge)
    );

    tec_ext_cond #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
        .clk(clk), .rst_n(rst_n), .pin(ext_clk_pin),
        .cfg(ext_q), .cfg_wr(wr_ext), .tick(ext_tick)
    );

    assign trig_hit = trig_edge && (mode_q == MODE_TRIG_START) && (src_q == SRC_TRIG_PIN);
    assign adv      = ext_tick && run_q;

    // Run bit: a trigger sets it, software may write it
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= 1'b0;
        else if (trig_hit) run_q <= 1'b1;
        else if (wr_run)   run_q <= wr_data[0];
    end

    // Trigger flag: set by trigger, cleared by writing 0
    always_ff @(posedge clk) begin
        if (!rst_n)                     flag_q <= 1'b0;
        else if (trig_hit)              flag_q <= 1'b1;
        else if (wr_flag && !wr_data[0]) flag_q <= 1'b0;
    end

    // Counter: software load, else advance with wrap at reload
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_cnt) cnt_q <= wr_data;
        else if (adv)    cnt_q <= (cnt_q == reload_q) ? '0 : cnt_q + CNT_W'(1);
    end

    assign count_o     = cnt_q;
    assign run_o       = run_q;
    assign trig_flag_o = flag_q;
endmodule

// File: rtl/tec_checker.sv
// Module: property checker for trig_ext_counter, attached by bind below.
module tec_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic             run,
    input logic             flag,
    input logic             tick,
    input logic             trig_hit,
    input logic             wr_cnt,
    input logic             wr_flag,
    input logic             wr_bit0
);
    logic adv;
    assign adv = tick && run;

    AST_TRIG_START: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |=> (run && flag)); // R2
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_cnt && cnt != reload) |=> (cnt == $past(cnt) + CNT_W'(1))); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !wr_cnt) |=> $stable(cnt)); // R5
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_cnt && cnt == reload) |=> (cnt == '0)); // R9
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && !wr_bit0 && !trig_hit) |=> !flag); // R10
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_flag) |=> flag); // R10
endmodule

bind trig_ext_counter tec_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .reload(reload_q), .run(run_q),
    .flag(flag_q), .tick(ext_tick), .trig_hit(trig_hit), .wr_cnt(wr_cnt),
    .wr_flag(wr_flag), .wr_bit0(wr_data[0])
);

// File: tb/trig_ext_counter_tb.sv
module trig_ext_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_clk_pin = 1'b0;
    logic        trig_pin = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count_o;
    logic        run_o, trig_flag_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit ext_pol = 0;
    int cur_filt = 0;

    trig_ext_counter u_dut (
        .clk(clk), .rst_n(rst_n), .ext_clk_pin(ext_clk_pin), .trig_pin(trig_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count_o(count_o), .run_o(run_o), .trig_flag_o(trig_flag_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (cur_filt + 6) @(negedge clk);
    endtask

    // Set polarity safely, then enable with prescaler and filter (restarts phase)
    task automatic cfg_ext(input bit pol, input int psc, input int filt);
        wr(3'd2, 16'(pol) << 6);
        ext_clk_pin = pol;
        ext_pol = pol;
        cur_filt = 0;
        settle();
        wr(3'd2, 16'h80 | (16'(pol) << 6) | (16'(psc) << 4) | 16'(filt));
        cur_filt = filt;
    endtask

    task automatic ext_pulse(input int hi, input int lo);
        @(negedge clk);
        ext_clk_pin = ~ext_pol;
        repeat (hi) @(negedge clk);
        ext_clk_pin = ext_pol;
        repeat (lo) @(negedge clk);
    endtask

    task automatic trig_level(input logic v);
        @(negedge clk);
        trig_pin = v;
        repeat (6) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_count(input logic [15:0] start, input int ticks,
                                              input logic [15:0] rel);
        logic [15:0] c = start;
        for (int i = 0; i < ticks; i++) c = (c == rel) ? 16'd0 : c + 16'd1;
        return c;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count", count_o, 0);
        chk("R1 run", run_o, 0);
        chk("R1 flag", trig_flag_o, 0);

        // Wrong source, then wrong mode: no start (R3)
        wr(3'd2, 16'h80);
        wr(3'd1, 16'h0046);
        ext_pulse(2, 4); settle();
        chk("R5 no count while stopped", count_o, 0);
        trig_level(1); trig_level(0);
        chk("R3 wrong source run", run_o, 0);
        chk("R3 wrong source flag", trig_flag_o, 0);
        wr(3'd1, 16'h0050);
        trig_level(1); trig_level(0);
        chk("R3 wrong mode run", run_o, 0);

        // Correct mode, falling-edge trigger; preload count (R12, R4, R2)
        wr(3'd1, 16'h0056);
        wr(3'd3, 16'h0001);
        wr(3'd6, 16'd7);
        chk("R12 count load", count_o, 7);
        trig_level(1);
        chk("R4 rising ignored with P=1", run_o, 0);
        @(negedge clk); trig_pin = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R2 run before 3rd edge", run_o, 0);
        @(negedge clk);
        chk("R2 run at 3rd edge", run_o, 1);
        chk("R2 flag at 3rd edge", trig_flag_o, 1);
        chk("R2 count kept", count_o, 7);

        // External clock latency (R5)
        @(negedge clk); ext_clk_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R5 count before 3rd edge", count_o, 7);
        @(negedge clk);
        chk("R5 count at 3rd edge", count_o, 8);
        ext_clk_pin = 1'b0; settle();

        // Flag clear rules (R10)
        wr(3'd4, 16'h0000);
        chk("R10 flag cleared", trig_flag_o, 0);
        wr(3'd4, 16'h0001);
        chk("R10 write 1 no effect", trig_flag_o, 0);

        // Both edges, retrigger while running (R4, R11)
        wr(3'd3, 16'h0003);
        trig_level(1);
        chk("R4 both-edge rise", trig_flag_o, 1);
        chk("R11 retrigger count", count_o, 8);
        wr(3'd4, 16'h0000);
        trig_level(0);
        chk("R4 both-edge fall", trig_flag_o, 1);
        chk("R11 retrigger run", run_o, 1);

        // Software stop and restart (R11)
        wr(3'd0, 16'h0000);
        chk("R11 sw stop", run_o, 0);
        ext_pulse(2, 4); settle();
        chk("R11 stopped no count", count_o, 8);
        wr(3'd0, 16'h0001);
        ext_pulse(2, 4); settle();
        chk("R11 restart count", count_o, 9);

        // External clock disabled (R5)
        wr(3'd2, 16'h0000);
        ext_pulse(2, 4); settle();
        chk("R5 ext disabled", count_o, 9);

        // Falling-edge counting (R6)
        cfg_ext(1, 0, 0);
        @(negedge clk); ext_clk_pin = 1'b0; settle();
        chk("R6 falling counted", count_o, 10);
        @(negedge clk); ext_clk_pin = 1'b1; settle();
        chk("R6 rising ignored", count_o, 10);

        // Prescaler divide by 4 (R7)
        cfg_ext(0, 2, 0);
        repeat (3) ext_pulse(2, 3);
        settle();
        chk("R7 three of four", count_o, 10);
        ext_pulse(2, 3); settle();
        chk("R7 fourth edge", count_o, 11);

        // Filter threshold N=4 (R8)
        cfg_ext(0, 0, 4);
        ext_pulse(3, 10); settle();
        chk("R8 short pulse rejected", count_o, 11);
        ext_pulse(4, 10); settle();
        chk("R8 full pulse accepted", count_o, 12);

        // Wrap at reload (R9)
        cfg_ext(0, 0, 0);
        wr(3'd5, 16'd5);
        wr(3'd6, 16'd5);
        ext_pulse(2, 3); settle();
        chk("R9 wrap to zero", count_o, 0);
        chk("R9 still running", run_o, 1);

        // Random configurations and pulse trains (R5, R6, R7, R8, R9)
        for (int it = 0; it < 40; it++) begin
            bit          pol   = 1'($urandom % 2);
            int          psc   = int'($urandom % 4);
            int          filt  = int'($urandom % 4);
            logic [15:0] rel   = 16'(8 + $urandom % 24);
            logic [15:0] start = 16'($urandom % (int'(rel) + 1));
            int          n     = 1 + int'($urandom % 20);
            cfg_ext(pol, psc, filt);
            wr(3'd5, rel);
            wr(3'd6, start);
            for (int p = 0; p < n; p++) begin
                ext_pulse(filt + 1 + int'($urandom % 3), filt + 1 + int'($urandom % 3));
            end
            settle();
            chk("R7 R8 R9 random train", count_o, exp_count(start, n >> psc, rel));
        end
        chk("R9 run after random", run_o, 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule